// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a small circular buffer of instruction bytes topped up ahead of the decoder. It issues single-byte reads on a request/grant bus only in cycles where the execution core reports that it is not using the bus, for example while it decodes or executes. The decoder drains the oldest byte through a valid/ready port, so fetching of later bytes overlaps with consumption of earlier ones.

When execution leaves the straight-line path, the core raises a flush and supplies a new target address. The block then throws away every queued byte in the same cycle, reloads its next-fetch address, and discards the data of any read that was already on its way. Storage uses separate read and write pointers that wrap around the buffer. Each pointer carries one extra wrap bit so that a full buffer can be told apart from an empty one.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset the buffer is empty (`dec_valid` = 0), no read is outstanding, and `rd_addr` equals the `RESET_ADDR` parameter (default 0).
- R2: `rd_req` is 1 exactly when `core_bus_idle` = 1, `flush` = 0, no read is outstanding and the buffer holds fewer than `2**DEPTH_LOG2` bytes (default 8).
- R3: `rd_addr` always shows the next fetch address. It rises by one for each byte written into the buffer and stays unchanged otherwise, except on a flush.
- R4: At most one read is outstanding. A request is accepted in a cycle with `rd_req` = 1 and `rd_gnt` = 1. After that `rd_req` stays 0 until the cycle after `rd_rvalid` returns, and `rd_rdata` is taken in that `rd_rvalid` cycle.
- R5: `dec_byte` is the oldest stored byte whenever `dec_valid` = 1. Bytes reach the decoder in the order they were fetched, and one byte leaves per cycle with `dec_valid` and `dec_ready` both high.
- R6: With a full buffer no read is requested. Requesting resumes in the cycle after one byte is popped.
- R7: A pop and a store in the same cycle leave the number of buffered bytes unchanged.
- R8: In a cycle with `flush` = 1, `dec_valid` and `rd_req` are 0. In the next cycle the buffer is empty and `rd_addr` equals the `flush_target` that was given.
- R9: If a read is outstanding when `flush` is raised, its returned byte is not stored and does not advance `rd_addr`. The next request uses the flush target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| core_bus_idle | input | 1 | Core leaves the bus free this cycle |
| flush | input | 1 | Discard queue and redirect fetching |
| flush_target | input | ADDR_W | New fetch address taken with flush |
| rd_req | output | 1 | Read request to the bus |
| rd_addr | output | ADDR_W | Byte address of the next fetch |
| rd_gnt | input | 1 | Bus accepts the request this cycle |
| rd_rvalid | input | 1 | Read data returned this cycle |
| rd_rdata | input | BYTE_W | Returned instruction byte |
| dec_valid | output | 1 | A byte is offered to the decoder |
| dec_byte | output | BYTE_W | Oldest buffered byte |
| dec_ready | input | 1 | Decoder takes the offered byte |

## Verification
The assertions assume that the bus returns `rd_rvalid` only for a read that was granted and is still outstanding, and never in the grant cycle itself. The bench's bus responder keeps to this. It records each granted address and answers it exactly once, after a random latency of one or more cycles. It never raises `rd_rvalid` while nothing is pending. Flushes, idle gaps, grant stalls and decoder back-pressure are drawn at random per cycle. The rates are chosen per phase so that full-buffer stalls, back-to-back streaming and flushes over in-flight reads all occur.

// File: rtl/ifq_pkg.sv
// Package: shared types for the instruction prefetch queue.
// Assumes instruction bytes are 8 bits wide.
package ifq_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] ibyte_t;
endpackage

// File: rtl/ifq_ring.sv
// Module: circular byte buffer with independent read and write pointers.
// Each pointer has one extra wrap bit so full and empty are distinguishable.
// Assumes push is never raised while full and pop never while empty;
// clear has priority over both.
module ifq_ring
    import ifq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   push,
    input  ibyte_t push_data,
    input  logic   pop,
    output ibyte_t head_data,
    output logic   empty,
    output logic   full
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PW    = DEPTH_LOG2 + 1;

    ibyte_t        slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Derive status from the pointer pair.
    always_comb begin
        empty     = (wr_ptr == rd_ptr);
        full      = (wr_ptr[PW-1] != rd_ptr[PW-1]) &&
                    (wr_ptr[PW-2:0] == rd_ptr[PW-2:0]);
        head_data = slots[rd_ptr[PW-2:0]];
    end

    // Write the incoming byte into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push && !clear) begin
            slots[wr_ptr[PW-2:0]] <= push_data;
        end
    end

    // Advance or reset the two circulating pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> !full);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> !empty);
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/ifq_fetch_ctl.sv
// Module: fetch sequencer. Issues one-byte reads when the core leaves the bus
// idle, tracks the single outstanding read, holds the next fetch address and
// marks a read as stale when a flush overtakes it.
// Assumes rd_rvalid only answers a granted, still-outstanding read.
module ifq_fetch_ctl #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] RESET_ADDR = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_bus_idle,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_target,
    input  logic              ring_full,
    input  logic              rd_gnt,
    input  logic              rd_rvalid,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              store
);
    logic [ADDR_W-1:0] fetch_pc;
    logic              outstanding;
    logic              stale;
    logic              granted;

    // Request, acceptance and store decisions for this cycle.
    always_comb begin
        rd_req  = core_bus_idle && !outstanding && !ring_full && !flush;
        granted = rd_req && rd_gnt;
        store   = rd_rvalid && outstanding && !stale && !flush;
        rd_addr = fetch_pc;
    end

    // Next-fetch address: reload on flush, step per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     fetch_pc <= ADDR_W'(RESET_ADDR);
        else if (flush) fetch_pc <= flush_target;
        else if (store) fetch_pc <= fetch_pc + 1'b1;
    end

    // Track the single read in flight and whether a flush made it stale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            stale       <= 1'b0;
        end else if (rd_rvalid) begin
            outstanding <= 1'b0;
            stale       <= 1'b0;
        end else begin
            if (granted)              outstanding <= 1'b1;
            if (flush && outstanding) stale       <= 1'b1;
        end
    end

    assert_req_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (core_bus_idle && !flush && !ring_full));
    assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
        granted |=> !rd_req);
    assert_addr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (rd_addr == $past(rd_addr) + 1'b1));
    assert_stale_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rvalid && stale) |-> !store);
    assert_flush_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rd_addr == $past(flush_target)));
endmodule

// File: rtl/instr_prefetch_queue.sv
// Module: instruction prefetch queue top. Joins the fetch sequencer to the
// circular buffer and presents the oldest byte to the decoder.
// Assumes the bus honours one outstanding read and answers with latency >= 1.
module instr_prefetch_queue
    import ifq_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DEPTH_LOG2 = 3,
    parameter logic [15:0] RESET_ADDR = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_bus_idle,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_target,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_gnt,
    input  logic              rd_rvalid,
    input  logic [BYTE_W-1:0] rd_rdata,
    output logic              dec_valid,
    output logic [BYTE_W-1:0] dec_byte,
    input  logic              dec_ready
);
    logic   ring_empty;
    logic   ring_full;
    logic   store;
    logic   pop;
    ibyte_t head;

    // Offer the head byte unless empty or being flushed.
    always_comb begin
        dec_valid = !ring_empty && !flush;
        dec_byte  = head;
        pop       = dec_valid && dec_ready;
    end

    ifq_fetch_ctl #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_bus_idle (core_bus_idle),
        .flush         (flush),
        .flush_target  (flush_target),
        .ring_full     (ring_full),
        .rd_gnt        (rd_gnt),
        .rd_rvalid     (rd_rvalid),
        .rd_req        (rd_req),
        .rd_addr       (rd_addr),
        .store         (store)
    );

    ifq_ring #(
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push      (store),
        .push_data (rd_rdata),
        .pop       (pop),
        .head_data (head),
        .empty     (ring_empty),
        .full      (ring_full)
    );

    assert_flush_hides_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!dec_valid && !rd_req));
    assert_steady_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store && pop && !ring_empty) |=> !ring_empty);
endmodule

// File: tb/tb_instr_prefetch_queue.sv
// Bench: behavioural reference model (byte queue, counters) compared each cycle.
module tb_instr_prefetch_queue;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              core_bus_idle = 1'b0;
    logic              flush = 1'b0;
    logic [ADDR_W-1:0] flush_target = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_gnt = 1'b0;
    logic              rd_rvalid = 1'b0;
    logic [7:0]        rd_rdata = '0;
    logic              dec_valid;
    logic [7:0]        dec_byte;
    logic              dec_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference model state
    logic [7:0]        mq[$];
    logic [ADDR_W-1:0] m_pc = '0;
    bit                m_out = 0;
    bit                m_stale = 0;
    // bus responder state
    bit                pend = 0;
    logic [ADDR_W-1:0] pend_addr = '0;
    int                pend_cnt = 0;

    instr_prefetch_queue #(.ADDR_W(ADDR_W), .DEPTH_LOG2(3)) dut (
        .clk(clk), .rst_n(rst_n), .core_bus_idle(core_bus_idle), .flush(flush),
        .flush_target(flush_target), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_gnt(rd_gnt), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .dec_valid(dec_valid), .dec_byte(dec_byte), .dec_ready(dec_ready));

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One cycle: drive at negedge, compare, advance model and responder.
    task automatic step(input string tag, input int idle_pct, input int rdy_pct,
                        input int gnt_pct, input int lat_max, input int fl_pct);
        bit e_req, e_valid, pop, store;
        string rtag;
        @(negedge clk);
        cycles++;
        core_bus_idle = ($urandom_range(99) < idle_pct);
        dec_ready     = ($urandom_range(99) < rdy_pct);
        rd_gnt        = ($urandom_range(99) < gnt_pct);
        flush         = ($urandom_range(99) < fl_pct);
        flush_target  = ADDR_W'($urandom);
        rd_rvalid     = pend && (pend_cnt == 0);
        rd_rdata      = rd_rvalid ? mem_byte(pend_addr) : 8'hxx;
        #1;
        e_req   = core_bus_idle && !m_out && (mq.size() < DEPTH) && !flush;
        e_valid = (mq.size() > 0) && !flush;
        rtag = flush ? "R8" : (m_out ? (m_stale ? "R9" : "R4") :
               ((mq.size() == DEPTH) ? "R6" : tag));
        check(rtag, "rd_req (R2)", rd_req, e_req);
        check(tag, "rd_addr (R3)", rd_addr, m_pc);
        check(flush ? "R8" : tag, "dec_valid (R5)", dec_valid, e_valid);
        if (e_valid) check(tag, "dec_byte (R5)", dec_byte, mq[0]);
        // responder
        if (rd_rvalid) pend = 0;
        else if (pend && pend_cnt > 0) pend_cnt--;
        if (rd_req && rd_gnt) begin
            pend = 1; pend_addr = rd_addr; pend_cnt = $urandom_range(lat_max - 1);
        end
        // reference model
        if (flush) begin
            mq.delete();
            m_pc = flush_target;
            m_stale = m_out && !rd_rvalid;
            if (rd_rvalid) m_out = 0;
        end else begin
            pop   = e_valid && dec_ready;
            store = rd_rvalid && m_out && !m_stale;
            if (pop) void'(mq.pop_front());
            if (store) begin
                mq.push_back(rd_rdata);
                m_pc = m_pc + 1'b1;
            end
            if (rd_rvalid) begin m_out = 0; m_stale = 0; end
            if (e_req && rd_gnt) m_out = 1;
        end
    endtask

    task automatic phase(input string tag, input int n, input int idle_pct, input int rdy_pct,
                         input int gnt_pct, input int lat_max, input int fl_pct);
        for (int i = 0; i < n; i++) step(tag, idle_pct, rdy_pct, gnt_pct, lat_max, fl_pct);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        core_bus_idle = 1'b1;
        #1;
        // R1: reset state seen at the ports
        check("R1", "dec_valid", dec_valid, 0);
        check("R1", "rd_addr", rd_addr, 0);
        check("R1", "rd_req (nothing outstanding)", rd_req, 1);
        phase("R2", 300, 60, 50, 70, 3, 0);     // mixed idle and grant gaps
        phase("R3", 200, 100, 70, 100, 1, 0);   // address stepping
        phase("R6", 40, 100, 0, 100, 2, 0);     // fill with decoder stalled
        phase("R6", 200, 100, 20, 100, 2, 0);   // trickle pops from full
        phase("R7", 300, 100, 100, 100, 1, 0);  // steady stream, pop with push
        phase("R8", 400, 80, 60, 80, 2, 8);     // frequent redirects
        phase("R9", 400, 100, 50, 100, 6, 10);  // flushes over long reads
        phase("R5", 400, 50, 50, 60, 4, 1);     // general ordering
        summary();
    end

    // watchdog
    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        summary();
    end
endmodule